// File: doc/BRIEF.md
# Thermal threshold throttle controller

This block compares each die temperature sample with two programmable throttle tiers and a separate trip level. From the comparisons it keeps sticky alarm flags, sets a two-bit throttle level and raises a shutdown request. The die reading is an unsigned whole number of degrees Celsius. It arrives with a one-cycle valid strobe, and each strobe yields a new decision on the next clock.

Software reaches the block through a 64-bit register file on a plain single-cycle bus. Reads are combinational on the address. A write takes effect at the clock edge. There are three registers. The control register holds the thresholds, the enables, the tier-one policy and the sticky flags. The sensor register holds the latest sample. The capability register reports a board strap that marks automatic throttling as unsupported; while that strap is high, the throttle output stays at zero.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset the throttle level is 0 and the shutdown request is low. The control register reads 0x7F000000: every threshold, enable, policy bit and flag is zero, and the trip level is at its all-ones reset value. The sensor register reads 0.
- R2: The control register sits at byte offset 0x08. Its fields are tier-one threshold [6:0], tier-one enable [7], tier-two threshold [14:8], tier-two enable [15], trip level [30:24], tier-one flag [32], tier-two flag [33] and policy [44]. Every other bit reads 0. A write to any other offset changes nothing, and an unmapped offset reads 0.
- R3: The sensor register at offset 0x10 holds the most recent valid sample in bits [6:0] and keeps it between strobes. The capability register at offset 0x20 returns the strap in bit 0.
- R4: A valid sample greater than or equal to the trip level raises the shutdown request one clock later. The trip level has no enable. The request stays high until reset.
- R5: A tier counts as reached when its enable is set and a valid sample is greater than or equal to its threshold. Its flag is set one clock later and stays set.
- R6: Writing 1 to a flag bit at offset 0x08 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R7: The throttle level is coded 0 = none, 1 = 50%, 2 = 90% and 3 = 100%. When tier one alone is reached, policy 0 gives 2 and policy 1 gives 1.
- R8: Priority runs from shutdown, to tier two, to tier one, to none. A pending or newly tripped shutdown gives level 3, and so does tier two.
- R9: The throttle level changes only on the clock after a valid sample, or when the strap clears it. Writes to the register file alone do not move it.
- R10: While the strap is high, the throttle level is 0 from the next clock on. Flags and shutdown keep working. When the strap drops, the level stays 0 until the next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Strobe marking a new temperature sample |
| temp_in | input | 7 | Die temperature in degrees Celsius |
| no_throttle_strap | input | 1 | High when automatic throttling is unsupported |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr |
| throttle_code | output | 2 | Throttle level (0 none, 1 50%, 2 90%, 3 100%) |
| shutdown_req | output | 1 | Sticky request to shut the device down |

## Verification
A wrong flag or shutdown register shows on the next clock, either in the read data at offset 0x08 or on shutdown_req. The bench compares both against its model on every cycle. A wrong decision in the throttle path shows on throttle_code one clock after the strobe that caused it. Because the level holds until the next sample, the error then stays visible on every following cycle. Corruption of the sensor or configuration state shows on the very next read of the matching offset.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
   typedef enum logic [1:0] {
      THR_NONE   = 2'd0,
      THR_HALF   = 2'd1,
      THR_NINETY = 2'd2,
      THR_FULL   = 2'd3
   } thr_level_e;

   localparam int unsigned OFS_CTRL  = 8;
   localparam int unsigned OFS_SENSE = 16;
   localparam int unsigned OFS_CAPS  = 32;

   localparam int unsigned LSB_T1   = 0;
   localparam int unsigned BIT_EN1  = 7;
   localparam int unsigned LSB_T2   = 8;
   localparam int unsigned BIT_EN2  = 15;
   localparam int unsigned LSB_TRIP = 24;
   localparam int unsigned BIT_ST1  = 32;
   localparam int unsigned BIT_POL  = 44;
   localparam int unsigned NUM_TIER = 2;
endpackage

// File: rtl/thermal_eval.sv
module thermal_eval
   import thermal_pkg::*;
#(
   parameter int unsigned TEMP_W = 7
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sample_vld,
   input  logic [TEMP_W-1:0]               sample,
   input  logic [NUM_TIER-1:0][TEMP_W-1:0] thr,
   input  logic [NUM_TIER-1:0]             thr_en,
   input  logic [TEMP_W-1:0]               trip_lvl,
   input  logic                            half_policy,
   input  logic                            strap,
   output logic [NUM_TIER-1:0]             tier_hit,
   output thr_level_e                      level_q,
   output logic                            shut_q
);
   logic       trip_hit;
   thr_level_e level_nxt;

   for (genvar t = 0; t < NUM_TIER; t++) begin : g_tier
      assign tier_hit[t] = sample_vld && thr_en[t] && (sample >= thr[t]);
   end

   assign trip_hit = sample_vld && (sample >= trip_lvl);

   always_comb begin
      if (shut_q || trip_hit)   level_nxt = THR_FULL;
      else if (tier_hit[1])     level_nxt = THR_FULL;
      else if (tier_hit[0])     level_nxt = half_policy ? THR_HALF : THR_NINETY;
      else                      level_nxt = THR_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= THR_NONE;
         shut_q  <= 1'b0;
      end else begin
         shut_q <= shut_q | trip_hit;
         if (strap)           level_q <= THR_NONE;
         else if (sample_vld) level_q <= level_nxt;
      end
   end

   p_shutdown_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shut_q) |-> shut_q);
   p_trip_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(trip_hit) |-> shut_q);
   p_strap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strap) |-> level_q == THR_NONE);
   p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_vld) && !$past(strap) |-> $stable(level_q));
   p_trip_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shut_q) && !$past(strap) |-> level_q == THR_FULL);
endmodule

// File: rtl/thermal_regs.sv
module thermal_regs
   import thermal_pkg::*;
#(
   parameter int unsigned     TEMP_W   = 7,
   parameter int unsigned     DATA_W   = 64,
   parameter int unsigned     ADDR_W   = 6,
   parameter logic [TEMP_W-1:0] RST_TRIP = '1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic                            bus_wr_en,
   input  logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               bus_rdata,
   input  logic                            sample_vld,
   input  logic [TEMP_W-1:0]               sample,
   input  logic                            strap,
   input  logic [NUM_TIER-1:0]             tier_hit,
   output logic [NUM_TIER-1:0][TEMP_W-1:0] thr,
   output logic [NUM_TIER-1:0]             thr_en,
   output logic [TEMP_W-1:0]               trip_lvl,
   output logic                            half_policy
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
   localparam logic [ADDR_W-1:0] A_CAPS  = ADDR_W'(OFS_CAPS);
   localparam int unsigned LSB_TH[NUM_TIER] = '{LSB_T1, LSB_T2};
   localparam int unsigned POS_EN[NUM_TIER] = '{BIT_EN1, BIT_EN2};

   if (TEMP_W < 1 || TEMP_W > 7) begin : g_bad_temp
      $error("thermal_regs: TEMP_W must fit a 7-bit field lane");
   end
   if (DATA_W < BIT_POL + 1) begin : g_bad_data
      $error("thermal_regs: DATA_W too narrow for the control layout");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("thermal_regs: ADDR_W too narrow for the register offsets");
   end

   logic                wr_ctrl;
   logic [NUM_TIER-1:0] clr;
   logic [NUM_TIER-1:0] stat_q;
   logic [TEMP_W-1:0]   temp_q;

   assign wr_ctrl = bus_wr_en && (bus_addr == A_CTRL);

   for (genvar t = 0; t < NUM_TIER; t++) begin : g_flag
      assign clr[t] = wr_ctrl && bus_wdata[BIT_ST1 + t];

      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(tier_hit[t]) |-> stat_q[t]);
      p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(stat_q[t]) && !$past(clr[t]) |-> stat_q[t]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr         <= '0;
         thr_en      <= '0;
         trip_lvl    <= RST_TRIP;
         half_policy <= 1'b0;
         stat_q      <= '0;
         temp_q      <= '0;
      end else begin
         stat_q <= (stat_q & ~clr) | tier_hit;
         if (sample_vld) temp_q <= sample;
         if (wr_ctrl) begin
            for (int t = 0; t < NUM_TIER; t++) begin
               thr[t]    <= bus_wdata[LSB_TH[t] +: TEMP_W];
               thr_en[t] <= bus_wdata[POS_EN[t]];
            end
            trip_lvl    <= bus_wdata[LSB_TRIP +: TEMP_W];
            half_policy <= bus_wdata[BIT_POL];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         for (int t = 0; t < NUM_TIER; t++) begin
            bus_rdata[LSB_TH[t] +: TEMP_W] = thr[t];
            bus_rdata[POS_EN[t]]           = thr_en[t];
            bus_rdata[BIT_ST1 + t]         = stat_q[t];
         end
         bus_rdata[LSB_TRIP +: TEMP_W] = trip_lvl;
         bus_rdata[BIT_POL]            = half_policy;
      end else if (bus_addr == A_SENSE) begin
         bus_rdata[TEMP_W-1:0] = temp_q;
      end else if (bus_addr == A_CAPS) begin
         bus_rdata[0] = strap;
      end
   end

   p_sensor_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_vld) |-> $stable(temp_q));
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
   import thermal_pkg::*;
#(
   parameter int unsigned       TEMP_W   = 7,
   parameter int unsigned       DATA_W   = 64,
   parameter int unsigned       ADDR_W   = 6,
   parameter logic [TEMP_W-1:0] RST_TRIP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              temp_valid,
   input  logic [TEMP_W-1:0] temp_in,
   input  logic              no_throttle_strap,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        throttle_code,
   output logic              shutdown_req
);
   logic [NUM_TIER-1:0][TEMP_W-1:0] thr;
   logic [NUM_TIER-1:0]             thr_en;
   logic [NUM_TIER-1:0]             tier_hit;
   logic [TEMP_W-1:0]               trip_lvl;
   logic                            half_policy;
   thr_level_e                      level_q;

   thermal_regs #(
      .TEMP_W(TEMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_TRIP(RST_TRIP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .sample_vld(temp_valid), .sample(temp_in), .strap(no_throttle_strap),
      .tier_hit(tier_hit), .thr(thr), .thr_en(thr_en),
      .trip_lvl(trip_lvl), .half_policy(half_policy)
   );

   thermal_eval #(.TEMP_W(TEMP_W)) u_eval (
      .clk(clk), .rst_n(rst_n),
      .sample_vld(temp_valid), .sample(temp_in),
      .thr(thr), .thr_en(thr_en), .trip_lvl(trip_lvl),
      .half_policy(half_policy), .strap(no_throttle_strap),
      .tier_hit(tier_hit), .level_q(level_q), .shut_q(shutdown_req)
   );

   assign throttle_code = level_q;
endmodule

// File: tb/thermal_throttle_ctrl_tb.sv
module thermal_throttle_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        temp_valid = 1'b0;
   logic [6:0]  temp_in = '0;
   logic        no_throttle_strap = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [1:0]  throttle_code;
   logic        shutdown_req;

   int checks = 0;
   int failures = 0;

   // reference model state
   int m_t1, m_e1, m_t2, m_e2, m_trip, m_pol, m_st1, m_st2, m_temp, m_lvl, m_shut;

   thermal_throttle_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
      .no_throttle_strap(no_throttle_strap), .bus_addr(bus_addr),
      .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .throttle_code(throttle_code), .shutdown_req(shutdown_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] ctrl_word(int t1, int e1, int t2, int e2, int tr, int pol);
      return 64'(t1) | (64'(e1) << 7) | (64'(t2) << 8) | (64'(e2) << 15)
           | (64'(tr) << 24) | (64'(pol) << 44);
   endfunction

   function automatic logic [63:0] exp_rd(logic [5:0] a);
      logic [63:0] v = '0;
      if (a == 6'h08)
         v = ctrl_word(m_t1, m_e1, m_t2, m_e2, m_trip, m_pol)
           | (64'(m_st1) << 32) | (64'(m_st2) << 33);
      else if (a == 6'h10) v = 64'(m_temp);
      else if (a == 6'h20) v = 64'(no_throttle_strap);
      return v;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // behavioural model, advanced on each edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_t1 = 0; m_e1 = 0; m_t2 = 0; m_e2 = 0; m_trip = 127; m_pol = 0;
         m_st1 = 0; m_st2 = 0; m_temp = 0; m_lvl = 0; m_shut = 0;
      end else begin
         int t;
         bit h1, h2, tr, wc;
         t  = int'(temp_in);
         h1 = temp_valid && m_e1 != 0 && t >= m_t1;
         h2 = temp_valid && m_e2 != 0 && t >= m_t2;
         tr = temp_valid && t >= m_trip;
         wc = bus_wr_en && bus_addr == 6'h08;
         if (no_throttle_strap) m_lvl = 0;
         else if (temp_valid) begin
            if (m_shut != 0 || tr) m_lvl = 3;
            else if (h2)           m_lvl = 3;
            else if (h1)           m_lvl = (m_pol != 0) ? 1 : 2;
            else                   m_lvl = 0;
         end
         if (tr) m_shut = 1;
         m_st1 = (h1 || (m_st1 != 0 && !(wc && bus_wdata[32]))) ? 1 : 0;
         m_st2 = (h2 || (m_st2 != 0 && !(wc && bus_wdata[33]))) ? 1 : 0;
         if (temp_valid) m_temp = t;
         if (wc) begin
            m_t1 = int'(bus_wdata[6:0]);   m_e1 = int'(bus_wdata[7]);
            m_t2 = int'(bus_wdata[14:8]);  m_e2 = int'(bus_wdata[15]);
            m_trip = int'(bus_wdata[30:24]); m_pol = int'(bus_wdata[44]);
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 throttle_code", 64'(throttle_code), 64'(m_lvl));
         chk("R4 shutdown_req", 64'(shutdown_req), 64'(m_shut));
         chk("R2 bus_rdata", bus_rdata, exp_rd(bus_addr));
      end
   end

   task automatic wr(logic [5:0] a, logic [63:0] d);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(posedge clk); #1;
      bus_wr_en = 1'b0; bus_wdata = '0;
   endtask

   task automatic smp(int t);
      temp_in = 7'(t); temp_valid = 1'b1;
      @(posedge clk); #1;
      temp_valid = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [5:0] a, logic [63:0] exp);
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
      @(posedge clk); #1;
   endtask

   task automatic out_chk(string tag, int code, int shut);
      @(negedge clk);
      chk(tag, 64'(throttle_code), 64'(code));
      chk(tag, 64'(shutdown_req), 64'(shut));
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      failures++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [63:0] cw;
      do_reset();
      // R1: reset state
      out_chk("R1 reset outputs", 0, 0);
      rd_chk("R1 ctrl reset", 6'h08, 64'h7F00_0000);
      rd_chk("R1 sensor reset", 6'h10, 64'h0);
      rd_chk("R3 caps strap low", 6'h20, 64'h0);

      // R2: field layout, other bits read zero
      cw = ctrl_word(40, 1, 60, 1, 90, 0);
      wr(6'h08, cw | 64'hFFFF_EFFC_80FF_0000);
      rd_chk("R2 ctrl readback", 6'h08, cw);

      smp(30);
      out_chk("R7 below tiers", 0, 0);
      smp(40);
      out_chk("R7 tier one policy0 is 90", 2, 0);
      rd_chk("R5 flag1 set at equality", 6'h08, cw | (64'd1 << 32));
      smp(39);
      out_chk("R7 back to none", 0, 0);
      rd_chk("R5 flag1 sticky", 6'h08, cw | (64'd1 << 32));

      cw = ctrl_word(40, 1, 60, 1, 90, 1);
      wr(6'h08, cw);
      out_chk("R9 write alone holds level", 0, 0);
      smp(50);
      out_chk("R7 tier one policy1 is 50", 1, 0);
      wr(6'h08, ctrl_word(10, 1, 12, 1, 90, 0));
      out_chk("R9 threshold change holds level", 1, 0);
      wr(6'h08, cw);
      smp(70);
      out_chk("R8 tier two wins", 3, 0);
      rd_chk("R5 both flags", 6'h08, cw | (64'd3 << 32));
      wr(6'h08, cw | (64'd1 << 32));
      rd_chk("R6 clear flag1 only", 6'h08, cw | (64'd1 << 33));

      smp(95);
      out_chk("R4 trip raises shutdown", 3, 1);
      smp(10);
      out_chk("R4 shutdown sticky, R8 full", 3, 1);

      do_reset();
      out_chk("R1 reset again", 0, 0);
      rd_chk("R1 ctrl after reset", 6'h08, 64'h7F00_0000);
      rd_chk("R1 sensor after reset", 6'h10, 64'h0);

      cw = ctrl_word(40, 0, 60, 1, 90, 0);
      wr(6'h08, cw);
      smp(50);
      out_chk("R5 disabled tier ignored", 0, 0);
      rd_chk("R5 no flag when disabled", 6'h08, cw);

      // set and clear in the same cycle
      cw = ctrl_word(40, 1, 60, 1, 90, 0);
      wr(6'h08, cw);
      bus_addr = 6'h08; bus_wdata = cw | (64'd1 << 32); bus_wr_en = 1'b1;
      temp_in = 7'd45; temp_valid = 1'b1;
      @(posedge clk); #1;
      bus_wr_en = 1'b0; temp_valid = 1'b0;
      rd_chk("R6 set wins over clear", 6'h08, cw | (64'd1 << 32));
      out_chk("R7 level after collision", 2, 0);

      no_throttle_strap = 1'b1;
      @(posedge clk); #1;
      out_chk("R10 strap forces none", 0, 0);
      rd_chk("R3 caps strap high", 6'h20, 64'h1);
      smp(70);
      out_chk("R10 no throttle under strap", 0, 0);
      rd_chk("R10 flags still set", 6'h08, cw | (64'd3 << 32));
      no_throttle_strap = 1'b0;
      @(posedge clk); #1;
      out_chk("R10 stays none until sample", 0, 0);
      smp(70);
      out_chk("R9 sample restores level", 3, 0);

      wr(6'h10, '1);
      wr(6'h20, '1);
      rd_chk("R3 sensor holds last sample", 6'h10, 64'd70);
      rd_chk("R2 ctrl unchanged by other writes", 6'h08, cw | (64'd3 << 32));
      rd_chk("R2 unmapped reads zero", 6'h18, 64'h0);
      out_chk("R2 outputs unchanged", 3, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule